// File: doc/BRIEF.md
# Glyph Row Pixel Serializer with Dot-Clock Divider

The block runs on a fast dot clock and keeps a three-bit phase counter that splits every character cell into eight dot periods. That one counter times the block's three outputs together. Its top bit is the processor clock, which runs at one eighth of the dot rate, for example 1 MHz from 8 MHz. It also sets a registered flag that marks the half of the cycle in which video logic may fetch from shared memory. Finally, it sets an active-low strobe that loads one glyph row byte into an eight-bit pixel shift register.

The load strobe is decoded from the last phase of the cell. The byte on the glyph input is therefore captured on the dot edge where the phase wraps from seven to zero, which comes right after the previous byte's last pixel. Pixels then leave most significant bit first, one per dot clock. A character address counter moves forward on the same edge as the load and wraps after a set number of cells. This counter is enough to drive a character generator while the board is being brought up.

Reset is synchronous and active low. It clears the shift register and the address counter. It never touches the phase counter, so the processor clock keeps running and the processor can see a clean reset.

Top module: `glyph_serializer`

## Requirements
- R1: `cpu_clk` repeats with a period of eight dot clocks. It is low for four dot periods (phases 0 to 3) and high for four (phases 4 to 7), and the phase starts at 0 at power-up.
- R2: `cpu_clk` keeps its eight-dot toggling while `rst_n` is low.
- R3: `load_n` is low for exactly one dot period out of every eight: phase 7, the last high dot period of `cpu_clk`.
- R4: The byte on `glyph_row` at the dot edge that ends a `load_n`-low period appears on `pixel_out` over the next eight dot periods, bit 7 first and bit 0 last.
- R5: While `rst_n` is low, `pixel_out` is 0. After release it stays 0 until the first load.
- R6: `char_addr` increases by one only on a load edge and wraps from CELLS-1 (default 79) to 0.
- R7: A dot edge with `rst_n` low sets `char_addr` to 0, and that edge takes priority over a load.
- R8: `fetch_win` is a registered output that is 1 exactly during the dot periods in which `cpu_clk` is 0.
- R9: Changes on `glyph_row` outside the load edge have no effect on `pixel_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dot | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset (does not stop `cpu_clk`) |
| glyph_row | input | 8 | Glyph row byte from the character generator |
| pixel_out | output | 1 | Serial pixel, one per dot clock |
| cpu_clk | output | 1 | Processor clock, dot clock divided by eight |
| load_n | output | 1 | Active-low parallel-load strobe (phase 7) |
| fetch_win | output | 1 | High while the video side owns shared memory |
| char_addr | output | 7 | Character address for bring-up |

## Verification
The bench changes `glyph_row` on every dot clock. A design that samples the byte one edge early or late, or that loads on any phase other than the wrap, would then emit a wrong pixel sequence and break R4 and R9. Reset is held for many cells and is also asserted in the middle of a cell and across a load edge. A divider that reset gated would freeze `cpu_clk`, and a load that won over reset would leak a byte onto the output. The run goes past one full address wrap, which catches an off-by-one at CELLS-1.

// File: rtl/glyph_ser_pkg.sv
// Shared helpers for the glyph serializer.
// Assumes: cell counts are at least 1.
package glyph_ser_pkg;
    localparam int unsigned PHASE_W_DEF = 3;
    localparam int unsigned CELLS_DEF   = 80;

    // Width of a counter that must hold 0 .. n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/glyph_phase_gen.sv
// Free-running dot phase counter and the timing outputs decoded from it.
// Assumes: never reset, so the processor clock runs through reset; the phase
// powers up at 0.
module glyph_phase_gen #(
    parameter int unsigned PHASE_W = glyph_ser_pkg::PHASE_W_DEF
) (
    input  logic clk,
    output logic cpu_clk,
    output logic load_n,
    output logic fetch_win
);
    logic [PHASE_W-1:0] phase_q = '0;
    logic [PHASE_W-1:0] phase_nxt;
    logic               fetch_q = 1'b1;
    logic               past_ok = 1'b0;

    // Next phase, wrapping naturally at 2**PHASE_W.
    always_comb phase_nxt = phase_q + 1'b1;

    // Advance the phase on every dot clock.
    always_ff @(posedge clk) phase_q <= phase_nxt;

    // Register the fetch window so it is high when the next phase is in the low half.
    always_ff @(posedge clk) fetch_q <= ~phase_nxt[PHASE_W-1];

    // Marks that one edge has passed, for the history-based checks.
    always_ff @(posedge clk) past_ok <= 1'b1;

    assign cpu_clk   = phase_q[PHASE_W-1];
    assign load_n    = ~(&phase_q);
    assign fetch_win = fetch_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!past_ok)
        phase_q == PHASE_W'($past(phase_q) + 1'b1)); // R2
    AST_LOAD_IN_HIGH: assert property (@(posedge clk)
        !load_n |-> cpu_clk); // R3
    AST_FALL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!past_ok)
        !load_n |=> (!cpu_clk && fetch_win)); // R8
endmodule

// File: rtl/glyph_pixel_shift.sv
// Parallel-load, MSB-first pixel shift register.
// Assumes: load_n is low for one dot per cell; reset wins over load.
module glyph_pixel_shift #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [PIX_W-1:0] glyph,
    output logic             pixel
);
    logic [PIX_W-1:0] sr_q;

    // Clear on reset, capture on the load strobe, otherwise shift left with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (!load_n) sr_q <= glyph;
        else              sr_q <= {sr_q[PIX_W-2:0], 1'b0};
    end

    assign pixel = sr_q[PIX_W-1];

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && rst_n) |=> (sr_q == $past(glyph))); // R4
    AST_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && rst_n) |=> (sr_q == {$past(sr_q[PIX_W-2:0]), 1'b0})); // R9
endmodule

// File: rtl/glyph_cell_addr.sv
// Character address counter: one step per cell, wraps at CELLS.
// Assumes: step is high for one dot per cell; reset wins over step.
module glyph_cell_addr #(
    parameter int unsigned CELLS  = glyph_ser_pkg::CELLS_DEF,
    parameter int unsigned ADDR_W = glyph_ser_pkg::cnt_width(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CELLS - 1);

    logic [ADDR_W-1:0] addr_q;

    // Clear on reset, otherwise step once per cell and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (step) addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end

    assign addr = addr_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && rst_n) |=> $stable(addr_q)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rst_n) |=> (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1))); // R6
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= LAST); // R6
endmodule

// File: rtl/glyph_serializer.sv
// Top: ties the phase generator, the pixel shifter and the cell address counter.
// Assumes: glyph_row is valid at the dot edge that ends the load_n-low period.
module glyph_serializer #(
    parameter int unsigned PHASE_W = glyph_ser_pkg::PHASE_W_DEF,
    parameter int unsigned CELLS   = glyph_ser_pkg::CELLS_DEF,
    localparam int unsigned PIX_W  = 1 << PHASE_W,
    localparam int unsigned ADDR_W = glyph_ser_pkg::cnt_width(CELLS)
) (
    input  logic              clk_dot,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  glyph_row,
    output logic              pixel_out,
    output logic              cpu_clk,
    output logic              load_n,
    output logic              fetch_win,
    output logic [ADDR_W-1:0] char_addr
);
    logic ld_n;

    glyph_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
        .clk(clk_dot), .cpu_clk(cpu_clk), .load_n(ld_n), .fetch_win(fetch_win)
    );

    glyph_pixel_shift #(.PIX_W(PIX_W)) u_shift (
        .clk(clk_dot), .rst_n(rst_n), .load_n(ld_n), .glyph(glyph_row), .pixel(pixel_out)
    );

    glyph_cell_addr #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk_dot), .rst_n(rst_n), .step(~ld_n), .addr(char_addr)
    );

    assign load_n = ld_n;

    AST_RESET_BLANK: assert property (@(posedge clk_dot)
        !rst_n |=> !pixel_out); // R5
    AST_RESET_ADDR: assert property (@(posedge clk_dot)
        !rst_n |=> (char_addr == '0)); // R7
endmodule

// File: tb/glyph_serializer_tb_top.sv
`timescale 1ns/1ps
module glyph_serializer_tb_top;
    localparam int CELLS = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] glyph = 8'h00;
    logic       pixel, cpu_clk, load_n, fetch_win;
    logic [6:0] addr;

    int checks = 0;
    int fails  = 0;
    bit armed  = 0;
    bit done   = 0;
    string tag_pix  = "R5";
    string tag_clk  = "R2";
    string tag_addr = "R7";

    // Reference model state
    int m_phase = 0;
    int m_sr    = 0;
    int m_addr  = 0;
    int m_fetch = 1;

    glyph_serializer #(.PHASE_W(3), .CELLS(CELLS)) dut_i (
        .clk_dot(clk), .rst_n(rst_n), .glyph_row(glyph), .pixel_out(pixel),
        .cpu_clk(cpu_clk), .load_n(load_n), .fetch_win(fetch_win), .char_addr(addr)
    );

    always #2.5 clk = ~clk;

    // Behavioural model: advance on every dot edge from the pre-edge values.
    always @(posedge clk) begin
        bit ld;
        ld = (m_phase == 7);
        if (!rst_n) begin
            m_sr = 0; m_addr = 0;
        end else if (ld) begin
            m_sr = int'(glyph);
            m_addr = (m_addr == CELLS - 1) ? 0 : m_addr + 1;
        end else begin
            m_sr = (m_sr * 2) % 256;
        end
        m_phase = (m_phase + 1) % 8;
        m_fetch = (m_phase < 4) ? 1 : 0;
        armed = 1;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output mid-cycle.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(tag_pix,  "pixel_out", int'(pixel), (m_sr >> 7) & 1);
            chk(tag_clk,  "cpu_clk",   int'(cpu_clk), (m_phase >= 4) ? 1 : 0);
            chk("R3",     "load_n",    int'(load_n), (m_phase == 7) ? 0 : 1);
            chk("R8",     "fetch_win", int'(fetch_win), m_fetch);
            chk(tag_addr, "char_addr", int'(addr), m_addr);
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            glyph = 8'($urandom);
        end
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R2 / R5 / R7: long reset while the glyph input moves
        run(21);
        @(negedge clk);
        chk("R5", "reset pixel", int'(pixel), 0);
        chk("R7", "reset addr", int'(addr), 0);
        rst_n = 1'b1;
        tag_clk = "R1"; tag_addr = "R6"; tag_pix = "R5";
        // Blank until the first load after release
        while (load_n !== 1'b0) run(1);
        tag_pix = "R4";
        run(8 * 4);
        // R9: glyph moves on every dot; only the load edge matters
        tag_pix = "R9";
        run(8 * 6);
        // R6: go beyond a full address wrap
        tag_pix = "R4";
        run(8 * (CELLS + 3));
        // R7: reset in mid-cell, then across a load edge
        run(3);
        rst_n = 1'b0; tag_clk = "R2"; tag_addr = "R7"; tag_pix = "R5";
        run(9);
        rst_n = 1'b1; tag_clk = "R1"; tag_addr = "R6";
        run(40);
        tag_pix = "R4";
        run(24);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule